// File: doc/BRIEF.md
# Handshake-Line Interrupt Flag Controller

This block is the control-line interrupt section of a classic parallel interface adapter. Four external handshake inputs (two for port A, two for port B) are synchronised into the clock domain and watched for transitions. The active edge of each line is chosen by software in a control register. Matching transitions latch into a seven-bit flag register. Three internal event sources (shift-register done and two timer events) set their flags directly. The flags are masked by an enable register and drive an active-low interrupt request output.

A small synchronous register bus gives software access to the two port output registers, their direction registers, the edge-control register, the flag register and the enable register. Reading or writing a port register acknowledges the interrupts of that port's handshake lines. The second line of each port can be placed in an "independent" mode, where its flag survives port accesses and only an explicit flag-register write clears it.

All control lines are expected to idle high. The synchroniser stages and the stored previous levels both reset to 1, so releasing reset with the lines high records no event.

Top module: `via_irq_ctrl`

## Requirements
- R1: In the edge-control register (offset 12), bit 0 governs line A1 and bit 4 governs line B1: a 1 makes a rising transition the event and a 0 makes a falling transition the event; the A1 flag is flag bit 1 and the B1 flag is flag bit 4.
- R2: For line A2 the rising/falling choice is edge-control bit 2 and the independent-mode bit is bit 1; for line B2 they are bits 6 and 5; the A2 flag is flag bit 0 and the B2 flag is flag bit 3.
- R3: A line's flag sets only when its synchronised level differs from the previously recorded level and the new level equals the selected polarity; a transition of the other polarity leaves the flag unchanged.
- R4: A one-cycle high pulse on the shift-register event input sets flag bit 2, on the timer-2 input flag bit 5 and on the timer-1 input flag bit 6, with no edge qualification.
- R5: Any read or write of port B (offset 0) clears flag bit 4, and clears flag bit 3 unless edge-control bit 5 is 1.
- R6: Any read or write of port A (offset 1 or its alias at offset 15) clears flag bit 1, and clears flag bit 0 unless edge-control bit 1 is 1.
- R7: Direction registers sit at offset 2 (port B) and 3 (port A); a port write changes only the output bits whose direction bit is 1, and a port read returns the output register on direction-1 bits and the input pins on direction-0 bits.
- R8: Reading the flag register (offset 13) returns the flags in bits 6:0 and a 1 in bit 7 when any enabled flag is set; writing it clears exactly the bits written with 1.
- R9: Writing the enable register (offset 14) with bit 7 = 1 sets the enable bits written with 1, with bit 7 = 0 clears them; it reads back with bit 7 always 1.
- R10: The active-low interrupt output is 0 exactly while some flag bit and its enable bit are both 1.
- R11: After reset all flags, enables, the edge-control register, direction and output registers are 0, and the interrupt output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ln_a1 | input | 1 | Port A first handshake line |
| ln_a2 | input | 1 | Port A second handshake line |
| ln_b1 | input | 1 | Port B first handshake line |
| ln_b2 | input | 1 | Port B second handshake line |
| sr_evt | input | 1 | Shift-register done pulse |
| t1_evt | input | 1 | Timer-1 event pulse |
| t2_evt | input | 1 | Timer-2 event pulse |
| pa_pins | input | 8 | Port A input pins |
| pb_pins | input | 8 | Port B input pins |
| pa_out | output | 8 | Port A output register |
| pb_out | output | 8 | Port B output register |
| pa_dir | output | 8 | Port A direction register |
| pb_dir | output | 8 | Port B direction register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions watch, on every cycle, that an edge-detector firing always agrees with the selected polarity, that no flag rises without a set event, that no flag falls without a clear source, that a port access leaves an independent A2 flag untouched and clears the B1 flag, and that a pending enabled flag holds the interrupt low. Which edge each control-register bit selects, how direction bits merge with pin values, the flag-register read-back, and the set/clear semantics of the enable register can only be shown by the bench's scenarios, which drive line transitions and bus accesses and compare read-back values.

// File: rtl/via_irq_pkg.sv
package via_irq_pkg;

  localparam int unsigned DW      = 8;
  localparam int unsigned AW      = 4;
  localparam int unsigned NFLAG   = 7;
  localparam int unsigned NLINE   = 4;
  localparam int unsigned SYNC_ST = 2;

  // flag bit positions
  localparam int unsigned FL_A2 = 0;
  localparam int unsigned FL_A1 = 1;
  localparam int unsigned FL_SR = 2;
  localparam int unsigned FL_B2 = 3;
  localparam int unsigned FL_B1 = 4;
  localparam int unsigned FL_T2 = 5;
  localparam int unsigned FL_T1 = 6;

  // line index inside the edge detector
  localparam int unsigned LN_A2 = 0;
  localparam int unsigned LN_A1 = 1;
  localparam int unsigned LN_B2 = 2;
  localparam int unsigned LN_B1 = 3;

  // register offsets
  localparam logic [AW-1:0] OFS_PB   = 4'h0;
  localparam logic [AW-1:0] OFS_PA   = 4'h1;
  localparam logic [AW-1:0] OFS_DIRB = 4'h2;
  localparam logic [AW-1:0] OFS_DIRA = 4'h3;
  localparam logic [AW-1:0] OFS_ECR  = 4'hC;
  localparam logic [AW-1:0] OFS_IFR  = 4'hD;
  localparam logic [AW-1:0] OFS_IER  = 4'hE;
  localparam logic [AW-1:0] OFS_PANH = 4'hF;

  // event when level changed and the new level is the chosen one
  function automatic logic edge_hit(logic prev, logic cur, logic rise_sel);
    return (prev != cur) && (cur == rise_sel);
  endfunction

  // chosen polarity per line, in line index order
  function automatic logic [NLINE-1:0] ecr_rise(logic [DW-1:0] ecr);
    logic [NLINE-1:0] r;
    r[LN_A2] = ecr[2];
    r[LN_A1] = ecr[0];
    r[LN_B2] = ecr[6];
    r[LN_B1] = ecr[4];
    return r;
  endfunction

  function automatic logic keep_a2(logic [DW-1:0] ecr);
    return ecr[1];
  endfunction

  function automatic logic keep_b2(logic [DW-1:0] ecr);
    return ecr[5];
  endfunction

  // only direction-1 bits take new data
  function automatic logic [DW-1:0] merge_out(logic [DW-1:0] old,
                                              logic [DW-1:0] wd,
                                              logic [DW-1:0] dir);
    return (old & ~dir) | (wd & dir);
  endfunction

  function automatic logic [DW-1:0] port_view(logic [DW-1:0] outr,
                                              logic [DW-1:0] pins,
                                              logic [DW-1:0] dir);
    return (outr & dir) | (pins & ~dir);
  endfunction

  // bit 7 picks set or clear of the selected enables
  function automatic logic [NFLAG-1:0] ier_next(logic [NFLAG-1:0] cur,
                                                logic [DW-1:0] wd);
    return wd[DW-1] ? (cur | wd[NFLAG-1:0]) : (cur & ~wd[NFLAG-1:0]);
  endfunction

endpackage

// File: rtl/via_sync_edge.sv
module via_sync_edge #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lines_i,
  input  logic [N-1:0] rise_i,
  output logic [N-1:0] level_o,
  output logic [N-1:0] fire_o
);
  import via_irq_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_line
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh   <= '1;
        prev <= 1'b1;
      end else begin
        sh   <= {sh[STAGES-2:0], lines_i[g]};
        prev <= sh[STAGES-1];
      end
    end

    assign level_o[g] = sh[STAGES-1];
    assign fire_o[g]  = edge_hit(prev, sh[STAGES-1], rise_i[g]);
  end

endmodule

// File: rtl/via_port_reg.sv
module via_port_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         out_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] view_o
);
  import via_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o <= '0;
      out_o <= '0;
    end else begin
      if (dir_we) dir_o <= wdata;
      if (out_we) out_o <= merge_out(out_o, wdata, dir_o);
    end
  end

  assign view_o = port_view(out_o, pins_i, dir_o);

endmodule

// File: rtl/via_flag_regs.sv
module via_flag_regs #(
  parameter int unsigned NF = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  input  logic          ier_we,
  input  logic [7:0]    ier_wd,
  output logic [NF-1:0] ifr_o,
  output logic [NF-1:0] ier_o,
  output logic          pend_o
);
  import via_irq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifr_o <= '0;
      ier_o <= '0;
    end else begin
      // a new event wins over a clear in the same cycle
      ifr_o <= (ifr_o & ~clr_i) | set_i;
      if (ier_we) ier_o <= ier_next(ier_o, ier_wd);
    end
  end

  assign pend_o = |(ifr_o & ier_o);

endmodule

// File: rtl/via_irq_ctrl.sv
module via_irq_ctrl
  import via_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ln_a1,
  input  logic          ln_a2,
  input  logic          ln_b1,
  input  logic          ln_b2,
  input  logic          sr_evt,
  input  logic          t1_evt,
  input  logic          t2_evt,
  input  logic [DW-1:0] pa_pins,
  input  logic [DW-1:0] pb_pins,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pa_dir,
  output logic [DW-1:0] pb_dir,
  output logic          irq_n
);

  logic [DW-1:0]    ecr_q;
  logic [NLINE-1:0] lines, rise, level, fire;
  logic [NFLAG-1:0] set_vec, clr_vec, ifr_wclr, ifr, ier;
  logic [DW-1:0]    pa_view, pb_view;
  logic             wr_en, acc_a, acc_b, pend;

  assign wr_en = bus_sel && bus_wr;
  assign acc_a = bus_sel && ((bus_addr == OFS_PA) || (bus_addr == OFS_PANH));
  assign acc_b = bus_sel && (bus_addr == OFS_PB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               ecr_q <= '0;
    else if (wr_en && bus_addr == OFS_ECR)    ecr_q <= bus_wdata;
  end

  assign lines[LN_A2] = ln_a2;
  assign lines[LN_A1] = ln_a1;
  assign lines[LN_B2] = ln_b2;
  assign lines[LN_B1] = ln_b1;
  assign rise         = ecr_rise(ecr_q);

  via_sync_edge #(.N(NLINE), .STAGES(SYNC_ST)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_i (lines),
    .rise_i  (rise),
    .level_o (level),
    .fire_o  (fire)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[FL_A2] = fire[LN_A2];
    set_vec[FL_A1] = fire[LN_A1];
    set_vec[FL_B2] = fire[LN_B2];
    set_vec[FL_B1] = fire[LN_B1];
    set_vec[FL_SR] = sr_evt;
    set_vec[FL_T2] = t2_evt;
    set_vec[FL_T1] = t1_evt;
  end

  assign ifr_wclr = (wr_en && bus_addr == OFS_IFR) ? bus_wdata[NFLAG-1:0] : '0;

  always_comb begin
    clr_vec = ifr_wclr;
    if (acc_a) begin
      clr_vec[FL_A1] = 1'b1;
      if (!keep_a2(ecr_q)) clr_vec[FL_A2] = 1'b1;
    end
    if (acc_b) begin
      clr_vec[FL_B1] = 1'b1;
      if (!keep_b2(ecr_q)) clr_vec[FL_B2] = 1'b1;
    end
  end

  via_flag_regs #(.NF(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .ier_we (wr_en && bus_addr == OFS_IER),
    .ier_wd (bus_wdata),
    .ifr_o  (ifr),
    .ier_o  (ier),
    .pend_o (pend)
  );

  assign irq_n = ~pend;

  via_port_reg #(.W(DW)) u_pa (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_we (wr_en && bus_addr == OFS_DIRA),
    .out_we (wr_en && acc_a),
    .wdata  (bus_wdata),
    .pins_i (pa_pins),
    .dir_o  (pa_dir),
    .out_o  (pa_out),
    .view_o (pa_view)
  );

  via_port_reg #(.W(DW)) u_pb (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_we (wr_en && bus_addr == OFS_DIRB),
    .out_we (wr_en && acc_b),
    .wdata  (bus_wdata),
    .pins_i (pb_pins),
    .dir_o  (pb_dir),
    .out_o  (pb_out),
    .view_o (pb_view)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_PB:            bus_rdata = pb_view;
      OFS_PA, OFS_PANH:  bus_rdata = pa_view;
      OFS_DIRB:          bus_rdata = pb_dir;
      OFS_DIRA:          bus_rdata = pa_dir;
      OFS_ECR:           bus_rdata = ecr_q;
      OFS_IFR:           bus_rdata = {pend, ifr};
      OFS_IER:           bus_rdata = {1'b1, ier};
      default:           bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/via_irq_ctrl_chk.sv
module via_irq_ctrl_chk
  import via_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NFLAG-1:0] ifr,
  input logic [NFLAG-1:0] ier,
  input logic [NFLAG-1:0] set_vec,
  input logic [NFLAG-1:0] clr_vec,
  input logic [NFLAG-1:0] ifr_wclr,
  input logic [NLINE-1:0] fire,
  input logic [NLINE-1:0] level,
  input logic [NLINE-1:0] rise,
  input logic [DW-1:0]    ecr_q,
  input logic             acc_a,
  input logic             acc_b,
  input logic             irq_n
);

  // R3
  fire_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & (level ^ rise)) == '0);

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ifr & ~$past(ifr) & ~$past(set_vec)) == '0));

  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(ifr) & ~$past(clr_vec) & ~ifr) == '0));

  // R6
  a2_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_a && ecr_q[1] && !set_vec[FL_A2] && !ifr_wclr[FL_A2])
      |=> (ifr[FL_A2] == $past(ifr[FL_A2])));

  // R5
  b1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_b && !set_vec[FL_B1]) |=> !ifr[FL_B1]);

  // R10
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ifr & ier) != '0) |-> !irq_n);

endmodule

bind via_irq_ctrl via_irq_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ifr      (ifr),
  .ier      (ier),
  .set_vec  (set_vec),
  .clr_vec  (clr_vec),
  .ifr_wclr (ifr_wclr),
  .fire     (fire),
  .level    (level),
  .rise     (rise),
  .ecr_q    (ecr_q),
  .acc_a    (acc_a),
  .acc_b    (acc_b),
  .irq_n    (irq_n)
);

// File: tb/via_irq_ctrl_test.sv
module via_irq_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       ln_a1 = 1'b1, ln_a2 = 1'b1, ln_b1 = 1'b1, ln_b2 = 1'b1;
  logic       sr_evt = 1'b0, t1_evt = 1'b0, t2_evt = 1'b0;
  logic [7:0] pa_pins = '0, pb_pins = '0;
  logic [7:0] pa_out, pb_out, pa_dir, pb_dir;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  via_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ln_a1(ln_a1), .ln_a2(ln_a2), .ln_b1(ln_b1), .ln_b2(ln_b2),
    .sr_evt(sr_evt), .t1_evt(t1_evt), .t2_evt(t2_evt),
    .pa_pins(pa_pins), .pb_pins(pb_pins), .pa_out(pa_out), .pb_out(pb_out),
    .pa_dir(pa_dir), .pb_dir(pb_dir), .irq_n(irq_n)
  );

  // fields: [11:4] edge-control value, [3:2] line (0 A1, 1 A2, 2 B1, 3 B2),
  // [1] level the line moves to, [0] expected flag afterwards
  localparam logic [11:0] VEC [13] = '{
    12'h001, 12'h002, 12'h013, 12'h005, 12'h047, 12'h044, 12'h10B,
    12'h00A, 12'h40F, 12'h00D, 12'h009, 12'h40C, 12'hFE1
  };

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_line(int idx, logic v);
    case (idx)
      0: ln_a1 = v;
      1: ln_a2 = v;
      2: ln_b1 = v;
      default: ln_b2 = v;
    endcase
  endtask

  function automatic int flag_pos(int idx);
    case (idx)
      0: return 1;
      1: return 0;
      2: return 4;
      default: return 3;
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R11 reset state
    check("R11 irq_n", {7'd0, irq_n}, 8'h01);
    bus_read(4'hD, rd); check("R11 flags", rd, 8'h00);
    bus_read(4'hE, rd); check("R11 enables", rd, 8'h80);
    bus_read(4'hC, rd); check("R11 edge ctrl", rd, 8'h00);
    check("R11 pa_out", pa_out, 8'h00);
    check("R11 pb_dir", pb_dir, 8'h00);

    // R1 R2 R3 edge table
    for (int i = 0; i < 13; i++) begin
      logic [7:0] pcr;
      int ln;
      logic to, ex;
      pcr = VEC[i][11:4]; ln = int'(VEC[i][3:2]); to = VEC[i][1]; ex = VEC[i][0];
      bus_write(4'hC, pcr);
      set_line(ln, ~to);
      settle();
      bus_write(4'hD, 8'h7F);
      set_line(ln, to);
      settle();
      bus_read(4'hD, rd);
      if (ex) check((ln < 2) ? "R1 edge sets flag" : "R2 edge sets flag",
                    {7'd0, rd[flag_pos(ln)]}, 8'h01);
      else    check("R3 wrong polarity ignored", {7'd0, rd[flag_pos(ln)]}, 8'h00);
    end
    bus_write(4'hC, 8'h00);
    ln_a1 = 1'b1; ln_a2 = 1'b1; ln_b1 = 1'b1; ln_b2 = 1'b1;
    settle();
    bus_write(4'hD, 8'h7F);

    // R10 interrupt and R6 port A acknowledge
    bus_write(4'hE, 8'h82);
    ln_a1 = 1'b0; settle();
    check("R10 irq asserted", {7'd0, irq_n}, 8'h00);
    bus_read(4'hD, rd); check("R8 flag readback", rd, 8'h82);
    bus_read(4'h1, rd);
    bus_read(4'hD, rd); check("R6 port A read clears A1", rd, 8'h00);
    check("R10 irq released", {7'd0, irq_n}, 8'h01);
    ln_a1 = 1'b1; settle();

    // R6 independent A2 survives, alias clears once dependent
    bus_write(4'hC, 8'h02);
    ln_a2 = 1'b0; settle();
    bus_read(4'h1, rd);
    bus_read(4'hD, rd); check("R6 independent A2 kept", rd, 8'h01);
    bus_write(4'hC, 8'h00);
    bus_read(4'hF, rd);
    bus_read(4'hD, rd); check("R6 alias clears A2", rd, 8'h00);
    ln_a2 = 1'b1; settle();

    // R5 port B write clears both, then independent B2
    ln_b1 = 1'b0; ln_b2 = 1'b0; settle();
    bus_read(4'hD, rd); check("R5 B flags set", rd, 8'h18);
    bus_write(4'h0, 8'h55);
    bus_read(4'hD, rd); check("R5 port B write clears", rd, 8'h00);
    bus_write(4'hC, 8'h20);
    ln_b2 = 1'b1; settle();
    ln_b2 = 1'b0; settle();
    ln_b1 = 1'b1; settle();
    bus_read(4'h0, rd);
    bus_read(4'hD, rd); check("R5 independent B2 kept", rd, 8'h08);
    bus_write(4'hC, 8'h00);
    ln_b2 = 1'b1; settle();
    bus_write(4'hD, 8'h7F);

    // R7 direction masking
    bus_write(4'h3, 8'h0F);
    bus_write(4'h1, 8'hFF);
    check("R7 masked port A write", pa_out, 8'h0F);
    pa_pins = 8'hA0;
    bus_read(4'h1, rd); check("R7 port A read merge", rd, 8'hAF);
    bus_write(4'h2, 8'hF0);
    bus_write(4'h0, 8'h3C);
    check("R7 masked port B write", pb_out, 8'h30);

    // R4 direct sources, R8 selective clear
    bus_write(4'hD, 8'h7F);
    @(negedge clk); sr_evt = 1'b1; @(negedge clk); sr_evt = 1'b0;
    @(negedge clk); t1_evt = 1'b1; @(negedge clk); t1_evt = 1'b0;
    @(negedge clk); t2_evt = 1'b1; @(negedge clk); t2_evt = 1'b0;
    bus_read(4'hD, rd); check("R4 direct events", rd, 8'h64);
    bus_write(4'hD, 8'h24);
    bus_read(4'hD, rd); check("R8 selective clear", rd, 8'h40);

    // R9 enable set and clear
    bus_write(4'hE, 8'hC0);
    bus_read(4'hE, rd); check("R9 enable set", rd, 8'hC2);
    check("R10 irq on T1", {7'd0, irq_n}, 8'h00);
    bus_read(4'hD, rd); check("R8 bit7 pending", rd, 8'hC0);
    bus_write(4'hE, 8'h42);
    bus_read(4'hE, rd); check("R9 enable clear", rd, 8'h80);
    check("R10 irq masked", {7'd0, irq_n}, 8'h01);
    bus_read(4'hD, rd); check("R8 flag kept when masked", rd, 8'h40);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule